// File: doc/BRIEF.md
# GPIO Controller with Programmable Edge Events

This block is a 32-pin general-purpose I/O port with a small register file on a single-cycle register bus. Each pin can be an input or an output. An output can drive both levels or act as open-drain, pulling low and releasing high. Every pin, whatever its direction, is watched by an edge detector whose sense is set per pin. A detected edge sets a sticky event bit. Software clears event bits by writing ones to them. An interrupt mask selects which pending events drive the single interrupt line.

The sense encoding is fixed at build time by a parameter. In the compact encoding, each pin has one control bit that chooses falling edges only or both edges. In the extended encoding, each pin has a two-bit field, spread across two control registers, that chooses falling, rising, both edges or none. All registers and pin vectors number pins with bit reversal: pin n sits at bit 31-n. Pin inputs pass through a two-flop synchronizer before they are read or edge-checked.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register reads as zero, `pin_oe` is all zero and `irq` is low.
- R2: Pin n occupies bit 31-n of every register and of `pin_in`, `pin_out` and `pin_oe`. Word addresses are: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, control 0x14, second control 0x18. Addresses with bits [1:0] nonzero are ignored.
- R3: A direction bit of 1 makes the pin an output. Without open-drain, its `pin_oe` bit is 1 and its `pin_out` bit equals the data bit. A direction bit of 0 makes the pin an input, and its `pin_oe` bit is 0.
- R4: For an output pin with its open-drain bit set, `pin_out` is 0. `pin_oe` is 1 while the data bit is 0 and 0 while the data bit is 1.
- R5: A data read returns the stored data bit for output pins and the synchronized pin level for input pins. A pin change becomes visible to a data read after two rising clock edges.
- R6: An edge on a pin sets its event bit at the third rising edge after the change. In the compact encoding, a control bit of 1 detects falling edges only and a control bit of 0 detects both edges.
- R7: A write to the event register clears each bit written as 1 and leaves each bit written as 0 unchanged. An edge detected in the same cycle as a clear of that bit leaves the bit set.
- R8: `irq` is high exactly when the event register AND the mask register is nonzero.
- R9: With `EXT_SENSE`=1, pins 0-15 use the control register and pins 16-31 use the second control register. The field of pin n sits at bits [(15-(n mod 16))*2 +: 2]. Field value 2'b10 detects falling edges, 2'b01 rising edges, 2'b00 both edges and 2'b11 none.
- R10: With `EXT_SENSE`=0, the second control register reads as zero and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, combinational from the address |
| pin_in | input | NPINS | Pad input levels, pin n at bit 31-n |
| pin_out | output | NPINS | Pad output levels |
| pin_oe | output | NPINS | Pad output enables |
| irq | output | 1 | Interrupt, high while an unmasked event is pending |

## Verification
A register write takes effect at the next rising edge. `pin_out` and `pin_oe` follow the registers combinationally, as do read data and `irq`. A pin change reaches a data read after two rising edges. It sets an event bit, and with it `irq`, after three.

The bench changes every input just after a falling edge and counts whole cycles from that point. It samples 1 ns after the falling edge that follows the edge on which the result is due. The same-cycle race between an edge and a clear is timed so that the clearing write lands on exactly the third edge. Two instances, one with each sense encoding, share the bus and the pins, so one stimulus checks both decodes.

// File: rtl/gpio_ev_pkg.sv
package gpio_ev_pkg;

    // Word index of each register (byte address >> 2)
    typedef enum logic [2:0] {
        IDX_DIR = 3'd0,
        IDX_ODE = 3'd1,
        IDX_DAT = 3'd2,
        IDX_EVT = 3'd3,
        IDX_MSK = 3'd4,
        IDX_CT1 = 3'd5,
        IDX_CT2 = 3'd6
    } reg_idx_e;

    // Two-bit sense code: bit1 clear enables rising, bit0 clear enables falling
    localparam logic [1:0] SNS_BOTH = 2'b00;
    localparam logic [1:0] SNS_RISE = 2'b01;
    localparam logic [1:0] SNS_FALL = 2'b10;
    localparam logic [1:0] SNS_NONE = 2'b11;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = raw_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur  = st_q.s2;
    assign prev = st_q.prev;

endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   prev,
    input  logic [2*W-1:0] sense,
    output logic [W-1:0]   hit
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic rise_en, fall_en;
        assign rise_en = ~sense[2*b+1];
        assign fall_en = ~sense[2*b];
        assign hit[b]  = (rise_en & cur[b] & ~prev[b])
                       | (fall_en & ~cur[b] & prev[b]);
    end

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_ev_pkg::*;
#(
    parameter int unsigned NPINS     = 32,
    parameter int unsigned ADDR_W    = 5,
    parameter bit          EXT_SENSE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);

    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam int unsigned HALF  = NPINS / 2;

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] ode;
        logic [NPINS-1:0] dat;
        logic [NPINS-1:0] evt;
        logic [NPINS-1:0] msk;
        logic [NPINS-1:0] ct1;
        logic [NPINS-1:0] ct2;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDX_W-1:0]   idx;
    logic               acc_ok;
    logic               wr_en;
    logic [NPINS-1:0]   clr_vec;
    logic [NPINS-1:0]   sync_cur, sync_prev, hit;
    logic [2*NPINS-1:0] sense;

    assign idx    = bus_addr[ADDR_W-1:2];
    assign acc_ok = bus_sel && (bus_addr[1:0] == 2'b00);
    assign wr_en  = acc_ok && bus_wr;

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (pin_in),
        .cur    (sync_cur),
        .prev   (sync_prev)
    );

    // Per-pin sense code, built from whichever encoding the parameter picks
    for (genvar b = 0; b < NPINS; b++) begin : g_sense
        if (EXT_SENSE) begin : g_ext
            if (b >= HALF) begin : g_lo_pins
                assign sense[2*b +: 2] = r_q.ct1[(b-HALF)*2 +: 2];
            end else begin : g_hi_pins
                assign sense[2*b +: 2] = r_q.ct2[b*2 +: 2];
            end
        end else begin : g_cmp
            assign sense[2*b +: 2] = r_q.ct1[b] ? SNS_FALL : SNS_BOTH;
        end
    end

    gpio_edge_det #(.W(NPINS)) u_edge (
        .cur   (sync_cur),
        .prev  (sync_prev),
        .sense (sense),
        .hit   (hit)
    );

    assign clr_vec = (wr_en && idx == IDX_W'(IDX_EVT)) ? bus_wdata : '0;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (idx == IDX_W'(IDX_DIR)) r_d.dir = bus_wdata;
            if (idx == IDX_W'(IDX_ODE)) r_d.ode = bus_wdata;
            if (idx == IDX_W'(IDX_DAT)) r_d.dat = bus_wdata;
            if (idx == IDX_W'(IDX_MSK)) r_d.msk = bus_wdata;
            if (idx == IDX_W'(IDX_CT1)) r_d.ct1 = bus_wdata;
            if (idx == IDX_W'(IDX_CT2)) r_d.ct2 = bus_wdata;
        end
        if (!EXT_SENSE) r_d.ct2 = '0;
        // New edges win over a same-cycle clear
        r_d.evt = (r_q.evt & ~clr_vec) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (acc_ok) begin
            case (idx)
                IDX_W'(IDX_DIR): bus_rdata = r_q.dir;
                IDX_W'(IDX_ODE): bus_rdata = r_q.ode;
                IDX_W'(IDX_DAT): bus_rdata = (r_q.dat & r_q.dir) | (sync_cur & ~r_q.dir);
                IDX_W'(IDX_EVT): bus_rdata = r_q.evt;
                IDX_W'(IDX_MSK): bus_rdata = r_q.msk;
                IDX_W'(IDX_CT1): bus_rdata = r_q.ct1;
                IDX_W'(IDX_CT2): bus_rdata = r_q.ct2;
                default:         bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = r_q.dat & ~r_q.ode;
    assign pin_oe  = r_q.dir & ~(r_q.ode & r_q.dat);
    assign irq     = |(r_q.evt & r_q.msk);

    // ---------------- assertions ----------------
    assert_hit_needs_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & ~(sync_cur ^ sync_prev)) == '0);

    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_W'(IDX_EVT)) |=> ((r_q.evt & $past(bus_wdata & ~hit)) == '0));

    assert_evt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(r_q.evt) & ~$past(clr_vec) & ~r_q.evt) == '0));

    assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (r_q.msk != '0));

    assert_oe_only_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~r_q.dir) == '0);

    if (!EXT_SENSE) begin : g_ct2_chk
        assert_ct2_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_ok && !bus_wr && idx == IDX_W'(IDX_CT2)) |-> (bus_rdata == '0));
    end

endmodule

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;

    localparam logic [4:0] A_DIR = 5'h00, A_ODE = 5'h04, A_DAT = 5'h08, A_EVT = 5'h0C,
                           A_MSK = 5'h10, A_CT1 = 5'h14, A_CT2 = 5'h18;

    localparam int K_RD0 = 0, K_RD1 = 1, K_OE = 2, K_OUT = 3, K_IRQ = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pin_in = '0;
    logic [31:0] rd0, rd1, pout0, pout1, poe0, poe1;
    logic        irq0, irq1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t exp_q[$];
    event  sample_ev;

    always #4 clk = ~clk;

    gpio_edge_ctrl #(.NPINS(32), .ADDR_W(5), .EXT_SENSE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd0),
        .pin_in(pin_in), .pin_out(pout0), .pin_oe(poe0), .irq(irq0));

    gpio_edge_ctrl #(.NPINS(32), .ADDR_W(5), .EXT_SENSE(1'b1)) u_dut_ext (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd1),
        .pin_in(pin_in), .pin_out(pout1), .pin_oe(poe1), .irq(irq1));

    // Monitor: pops the expected item and compares with the live output
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = exp_q.pop_front();
                case (it.kind)
                    K_RD0:   act = rd0;
                    K_RD1:   act = rd1;
                    K_OE:    act = poe0;
                    K_OUT:   act = pout0;
                    default: act = {31'd0, irq0};
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%08h expected=%08h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_now(input int kind, input logic [31:0] exp, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        exp_q.push_back(it);
        #1;
        ->sample_ev;
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input int kind, input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        expect_now(kind, exp, req);
    endtask

    task automatic out_chk(input int kind, input logic [31:0] exp, input string req);
        @(negedge clk);
        expect_now(kind, exp, req);
    endtask

    // Change pins, then let three rising edges pass so events are latched
    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic evt_pair(input logic [31:0] e0, input logic [31:0] e1, input string req);
        rd_chk(K_RD0, A_EVT, e0, req);
        rd_chk(K_RD1, A_EVT, e1, req);
        wr(A_EVT, 32'hFFFF_FFFF);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(K_RD0, A_DIR, 32'h0, "R1");
        rd_chk(K_RD0, A_EVT, 32'h0, "R1");
        rd_chk(K_RD0, A_CT1, 32'h0, "R1");
        out_chk(K_OE, 32'h0, "R1");
        out_chk(K_IRQ, 32'h0, "R1");

        // R2/R3: pin 0 (bit31) and pin 31 (bit0) as outputs
        wr(A_DIR, 32'h8000_0001);
        wr(A_DAT, 32'h8000_0000);
        out_chk(K_OE, 32'h8000_0001, "R3");
        out_chk(K_OUT, 32'h8000_0000, "R2");
        rd_chk(K_RD0, A_DAT, 32'h8000_0000, "R3");

        // R4 open-drain on pin 31
        wr(A_ODE, 32'h0000_0001);
        out_chk(K_OE, 32'h8000_0001, "R4");
        wr(A_DAT, 32'h8000_0001);
        out_chk(K_OE, 32'h8000_0000, "R4");
        out_chk(K_OUT, 32'h8000_0000, "R4");
        rd_chk(K_RD0, 5'h09, 32'h0, "R2");

        // R5 input readback two edges after change
        @(negedge clk);
        pin_in = 32'h0000_F000;
        @(negedge clk);
        rd_chk(K_RD0, A_DAT, 32'h8000_F001, "R5");

        // R6 both-edge default, R8 irq
        rd_chk(K_RD0, A_EVT, 32'h0000_F000, "R6");
        rd_chk(K_RD1, A_EVT, 32'h0000_F000, "R9");
        out_chk(K_IRQ, 32'h0, "R8");
        wr(A_MSK, 32'h0000_1000);
        out_chk(K_IRQ, 32'h1, "R8");

        // R7 write-one-to-clear
        wr(A_EVT, 32'h0000_3000);
        rd_chk(K_RD0, A_EVT, 32'h0000_C000, "R7");
        out_chk(K_IRQ, 32'h0, "R8");
        wr(A_EVT, 32'h0000_0000);
        rd_chk(K_RD0, A_EVT, 32'h0000_C000, "R7");
        wr(A_EVT, 32'hFFFF_FFFF);
        rd_chk(K_RD0, A_EVT, 32'h0, "R7");
        rd_chk(K_RD1, A_EVT, 32'h0, "R7");

        // R6 falling-only in compact encoding
        wr(A_CT1, 32'h0000_F000);
        set_pins(32'h0000_0000);
        evt_pair(32'h0000_F000, 32'h0000_F000, "R6");
        set_pins(32'h0000_F000);
        evt_pair(32'h0000_0000, 32'h0000_F000, "R6");

        // R10 / R9 second control register
        wr(A_CT2, 32'h9300_0000);
        rd_chk(K_RD0, A_CT2, 32'h0, "R10");
        rd_chk(K_RD1, A_CT2, 32'h9300_0000, "R9");
        set_pins(32'h0000_0000);
        evt_pair(32'h0000_F000, 32'h0000_A000, "R9");
        set_pins(32'h0000_F000);
        evt_pair(32'h0000_0000, 32'h0000_6000, "R9");

        // R9 first control register field of pin 0 (bits 31:30 = 01, rising)
        wr(A_CT1, 32'h4000_F000);
        set_pins(32'h8000_F000);
        evt_pair(32'h8000_0000, 32'h8000_0000, "R9");
        set_pins(32'h0000_F000);
        evt_pair(32'h8000_0000, 32'h0000_0000, "R9");

        // R7 edge in same cycle as clear wins
        @(negedge clk);
        pin_in = 32'h0000_F100;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_EVT; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd_chk(K_RD0, A_EVT, 32'h0000_0100, "R7");
        rd_chk(K_RD1, A_EVT, 32'h0000_0100, "R7");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule